// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit address pointers for an 8051-class processor core: a main pointer and a shadow pointer. A control register chooses which of the two is active. The active pointer drives the 16-bit address output. Software sees it through the usual low and high data-pointer byte registers, at SFR addresses 0x82 and 0x83, and can write it there.

Each pointer has its own post-access adjust mode. After an access, the pointer can stay as it is, count up, count down, or flip its least significant bit. The unit can also swap the active pointer after every pointer-based access. With the swap enabled, a copy loop can read through one pointer and write through the other, and software never has to reload either pointer.

The core reports each memory access on two pins. `acc_valid` marks that an access takes place, and `acc_via_ptr` marks that the access uses the data pointer as its address. Only accesses with both pins high adjust a pointer or swap the selection. Accesses indexed by the program counter or by a register are ignored.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset, both pointers are 0x0000, the control register reads 0x00 and `active_ptr` is 0x0000.
- R2: The control register is at SFR address 0xA7. Its fields are: bit 0 is the select, bits 3:2 are the main pointer mode, bits 5:4 are the shadow pointer mode and bit 6 is the auto-swap enable. Bits 7 and 1 ignore writes and read as 0, so a write of 0xFF reads back as 0x7D.
- R3: With select 0, the main pointer drives `active_ptr` and the reads of 0x82 (low byte) and 0x83 (high byte). With select 1, the shadow pointer drives them.
- R4: A write to 0x82 or 0x83 changes only that byte of the pointer that is selected. The other pointer does not change.
- R5: Mode 01 adds one to the pointer after each pointer-based access, and 0xFFFF wraps to 0x0000.
- R6: Mode 10 subtracts one from the pointer after each pointer-based access, and 0x0000 wraps to 0xFFFF.
- R7: Mode 11 inverts only bit 0 of the pointer after each pointer-based access. Mode 00 leaves the pointer unchanged.
- R8: An access with `acc_via_ptr` low leaves both pointers and the select bit unchanged.
- R9: When the auto-swap bit is 1, each pointer-based access inverts the select bit. When the bit is 0, only a software write changes the select bit.
- R10: An access applies only the mode of the pointer that was active during that access, and only to that pointer. The other pointer holds its value.
- R11: When an access falls in the same cycle as an SFR write, the write wins. A write to 0x82 or 0x83 stores its byte and cancels that cycle's adjust of the selected pointer. A write to 0xA7 loads the control register and cancels that cycle's swap.
- R12: Writing 0x55 to the control register sets both pointers to increment mode, enables auto-swap and selects the shadow pointer. Accesses then alternate between the two pointers, and each pointer advances by one per access that uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_re | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | SFR read data; 0 when no read is active or no register matches the address |
| acc_valid | input | 1 | A memory access takes place this cycle |
| acc_via_ptr | input | 1 | The access is addressed through the data pointer |
| active_ptr | output | 16 | Value of the selected pointer |

## Verification
The bench drives both pointers across the 16-bit wrap in each direction. A design with an 8-bit carry, or with no wrap at all, would show 0xFF00 or a stuck value where 0x0000 and 0xFFFF are expected. It also places a byte write and a control write in the same cycle as an access. A design that lets the adjust or the swap win would return 0x0000 instead of 0xFF10, or a flipped select bit. Other checks catch a design that adjusts the wrong pointer after a swap, a design that honours accesses with `acc_via_ptr` low, and a design that shows the unimplemented bits on readback. A short run of the 0x55 copy loop confirms that the two pointers alternate.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  // Post-access adjust mode of one pointer
  typedef enum logic [1:0] {
    MOD_HOLD = 2'b00,
    MOD_INC  = 2'b01,
    MOD_DEC  = 2'b10,
    MOD_FLIP = 2'b11
  } dp_mode_e;

  // Implemented control fields; the bit positions are fixed by the select decode
  typedef struct packed {
    logic     auto_swap;
    dp_mode_e mode_shadow;
    dp_mode_e mode_main;
    logic     sel;
  } dp_ctrl_t;

  localparam int unsigned NUM_PTR = 2;

endpackage

// File: rtl/dptr_modify.sv
module dptr_modify
  import dptr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  dp_mode_e     mode,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (mode)
      MOD_INC:  nxt = cur + ONE;
      MOD_DEC:  nxt = cur - ONE;
      MOD_FLIP: nxt = cur ^ ONE;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned LANES = W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_wr,
  input  logic [7:0]       lane_data,
  input  logic             step_en,
  input  dp_mode_e         mode,
  output logic [W-1:0]     value
);

  logic [W-1:0] stepped;
  logic [W-1:0] merged;

  dptr_modify #(.W(W)) u_mod (
    .cur (value),
    .mode(mode),
    .nxt (stepped)
  );

  // Each lane takes the written byte or keeps its current value
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*8 +: 8] = lane_wr[i] ? lane_data : value[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (|lane_wr) begin
      value <= merged;
    end else if (step_en) begin
      value <= stepped;
    end
  end

endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [7:0] wr_data,
  input  logic     step,
  output dp_ctrl_t ctrl,
  output logic [7:0] rd_data
);

  logic unused_rsvd;
  assign unused_rsvd = wr_data[7] ^ wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.auto_swap   <= wr_data[6];
      ctrl.mode_shadow <= dp_mode_e'(wr_data[5:4]);
      ctrl.mode_main   <= dp_mode_e'(wr_data[3:2]);
      ctrl.sel         <= wr_data[0];
    end else if (step && ctrl.auto_swap) begin
      ctrl.sel <= ~ctrl.sel;
    end
  end

  assign rd_data = {1'b0, ctrl.auto_swap, ctrl.mode_shadow, ctrl.mode_main, 1'b0, ctrl.sel};

endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PTR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h82
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              sfr_we,
  input  logic              sfr_re,
  output logic [7:0]        sfr_rdata,
  input  logic              acc_valid,
  input  logic              acc_via_ptr,
  output logic [PTR_W-1:0]  active_ptr
);

  localparam int unsigned LANES = PTR_W / 8;

  dp_ctrl_t         ctrl;
  logic [7:0]       ctrl_rd;
  logic             ctrl_wr;
  logic             step;
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] lane_wr;
  logic [PTR_W-1:0] ptr_q [NUM_PTR];
  logic [PTR_W-1:0] main_ptr;
  logic [PTR_W-1:0] shadow_ptr;

  assign step    = acc_valid & acc_via_ptr;
  assign ctrl_wr = sfr_we && (sfr_addr == CTRL_ADDR);

  for (genvar i = 0; i < LANES; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(i);
    assign lane_hit[i] = (sfr_addr == LANE_ADDR);
    assign lane_wr[i]  = sfr_we & lane_hit[i];
  end

  dptr_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wr_data(sfr_wdata),
    .step   (step),
    .ctrl   (ctrl),
    .rd_data(ctrl_rd)
  );

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    logic             mine;
    logic [LANES-1:0] my_wr;
    dp_mode_e         my_mode;

    assign mine    = (ctrl.sel == k[0]);
    assign my_wr   = mine ? lane_wr : '0;
    assign my_mode = (k == 0) ? ctrl.mode_main : ctrl.mode_shadow;

    dptr_reg #(.W(PTR_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_wr  (my_wr),
      .lane_data(sfr_wdata),
      .step_en  (step & mine),
      .mode     (my_mode),
      .value    (ptr_q[k])
    );
  end

  assign main_ptr   = ptr_q[0];
  assign shadow_ptr = ptr_q[1];
  assign active_ptr = ctrl.sel ? shadow_ptr : main_ptr;

  always_comb begin
    sfr_rdata = '0;
    if (sfr_re) begin
      if (sfr_addr == CTRL_ADDR) begin
        sfr_rdata = ctrl_rd;
      end
      for (int i = 0; i < LANES; i++) begin
        if (lane_hit[i]) begin
          sfr_rdata = active_ptr[i*8 +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/dual_dptr_unit_chk.sv
module dual_dptr_unit_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PTR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_we,
  input logic              sfr_re,
  input logic [7:0]        sfr_rdata,
  input logic              acc_valid,
  input logic              acc_via_ptr,
  input logic [PTR_W-1:0]  main_ptr,
  input logic [PTR_W-1:0]  shadow_ptr,
  input logic              sel,
  input logic              auto_en,
  input logic [1:0]        mode0,
  input logic [1:0]        mode1
);

  logic stp;
  logic cwr;
  assign stp = acc_valid && acc_via_ptr;
  assign cwr = sfr_we && (sfr_addr == CTRL_ADDR);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_re && sfr_addr == CTRL_ADDR) |-> (sfr_rdata[7] == 1'b0 && sfr_rdata[1] == 1'b0)); // R2

  AST_INC_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && !sel && mode0 == 2'b01 && !sfr_we) |=> (main_ptr == $past(main_ptr) + PTR_W'(1))); // R5

  AST_DEC_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && sel && mode1 == 2'b10 && !sfr_we) |=> (shadow_ptr == $past(shadow_ptr) - PTR_W'(1))); // R6

  AST_FLIP_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && !sel && mode0 == 2'b11 && !sfr_we) |=> (main_ptr == ($past(main_ptr) ^ PTR_W'(1)))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stp && !sfr_we) |=> ($stable(main_ptr) && $stable(shadow_ptr) && $stable(sel))); // R8

  AST_AUTO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && auto_en && !cwr) |=> (sel != $past(sel))); // R9

  AST_MANUAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !cwr) |=> $stable(sel)); // R9

  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stp && !sel && !sfr_we) |=> $stable(shadow_ptr)); // R10

endmodule

bind dual_dptr_unit dual_dptr_unit_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sfr_addr   (sfr_addr),
  .sfr_we     (sfr_we),
  .sfr_re     (sfr_re),
  .sfr_rdata  (sfr_rdata),
  .acc_valid  (acc_valid),
  .acc_via_ptr(acc_via_ptr),
  .main_ptr   (main_ptr),
  .shadow_ptr (shadow_ptr),
  .sel        (ctrl.sel),
  .auto_en    (ctrl.auto_swap),
  .mode0      (ctrl.mode_main),
  .mode1      (ctrl.mode_shadow)
);

// File: tb/dual_dptr_unit_bench.sv
module dual_dptr_unit_bench;

  localparam logic [7:0] A_CTRL = 8'hA7;
  localparam logic [7:0] A_LO   = 8'h82;
  localparam logic [7:0] A_HI   = 8'h83;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic [7:0]  sfr_wdata = '0;
  logic        sfr_we = 1'b0;
  logic        sfr_re = 1'b0;
  logic [7:0]  sfr_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_via_ptr = 1'b0;
  logic [15:0] active_ptr;

  always #5 clk = ~clk;

  dual_dptr_unit u_dual_dptr_unit (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata),
    .acc_valid(acc_valid), .acc_via_ptr(acc_via_ptr), .active_ptr(active_ptr)
  );

  typedef struct {
    string       tag;
    bit          is_ptr;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = it.is_ptr ? active_ptr : {8'h00, sfr_rdata};
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic acc(input bit via);
    @(negedge clk);
    acc_valid = 1'b1; acc_via_ptr = via;
    @(negedge clk);
    acc_valid = 1'b0; acc_via_ptr = 1'b0;
  endtask

  task automatic wr_acc(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    acc_valid = 1'b1; acc_via_ptr = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0; acc_valid = 1'b0; acc_via_ptr = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    sfr_addr = a; sfr_re = 1'b1;
    #1;
    it.tag = tag; it.is_ptr = 1'b0; it.exp = {8'h00, e};
    q.push_back(it);
    ->mon_ev;
    #1;
    sfr_re = 1'b0;
  endtask

  task automatic exp_ptr(input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.tag = tag; it.is_ptr = 1'b1; it.exp = e;
    q.push_back(it);
    ->mon_ev;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    exp_ptr(16'h0000, "R1 pointer after reset");
    exp_rd(A_CTRL, 8'h00, "R1 control after reset");
    exp_rd(A_HI, 8'h00, "R1 high byte after reset");
    // R2 reserved bits
    wr(A_CTRL, 8'hFF);
    exp_rd(A_CTRL, 8'h7D, "R2 control readback of 0xFF");
    wr(A_CTRL, 8'h00);
    // R3 / R4 routing and byte writes
    wr(A_LO, 8'h34); wr(A_HI, 8'h12);
    exp_ptr(16'h1234, "R4 main written by bytes");
    wr(A_CTRL, 8'h01);
    exp_ptr(16'h0000, "R3 shadow selected");
    wr(A_LO, 8'hCD); wr(A_HI, 8'hAB);
    exp_rd(A_LO, 8'hCD, "R3 low byte of shadow");
    exp_rd(A_HI, 8'hAB, "R3 high byte of shadow");
    wr(A_CTRL, 8'h00);
    exp_ptr(16'h1234, "R4 main untouched by shadow writes");
    // R5 increment wrap, R8 non-pointer access
    wr(A_CTRL, 8'h04);
    wr(A_LO, 8'hFF); wr(A_HI, 8'hFF);
    acc(1'b1);
    exp_ptr(16'h0000, "R5 increment wraps");
    acc(1'b0);
    exp_ptr(16'h0000, "R8 non-pointer access ignored");
    // R6 decrement wrap
    wr(A_CTRL, 8'h08);
    acc(1'b1);
    exp_ptr(16'hFFFF, "R6 decrement wraps");
    // R7 flip and hold
    wr(A_CTRL, 8'h0C);
    acc(1'b1);
    exp_ptr(16'hFFFE, "R7 lsb flip");
    acc(1'b1);
    exp_ptr(16'hFFFF, "R7 lsb flip back");
    wr(A_CTRL, 8'h00);
    acc(1'b1);
    exp_ptr(16'hFFFF, "R7 hold mode");
    // R10 per-pointer modes
    wr(A_CTRL, 8'h11);
    acc(1'b1);
    exp_ptr(16'hABCE, "R10 shadow uses its own mode");
    wr(A_CTRL, 8'h10);
    acc(1'b1);
    exp_ptr(16'hFFFF, "R10 main not using shadow mode");
    wr(A_CTRL, 8'h11);
    exp_ptr(16'hABCE, "R10 shadow held while main active");
    // R9 auto swap
    wr(A_CTRL, 8'h40);
    acc(1'b1);
    exp_rd(A_CTRL, 8'h41, "R9 swap after access");
    acc(1'b1);
    exp_rd(A_CTRL, 8'h40, "R9 swap back");
    acc(1'b0);
    exp_rd(A_CTRL, 8'h40, "R8 no swap on non-pointer access");
    wr(A_CTRL, 8'h00);
    acc(1'b1);
    exp_rd(A_CTRL, 8'h00, "R9 no swap when disabled");
    // R11 conflicts
    wr(A_CTRL, 8'h04);
    wr_acc(A_LO, 8'h10);
    exp_ptr(16'hFF10, "R11 byte write beats increment");
    wr(A_CTRL, 8'h44);
    wr_acc(A_CTRL, 8'h04);
    exp_rd(A_CTRL, 8'h04, "R11 control write beats swap");
    exp_ptr(16'hFF11, "R11 pointer still steps on control write");
    // R12 copy loop setup
    wr(A_CTRL, 8'h00);
    wr(A_LO, 8'h00); wr(A_HI, 8'h00);
    wr(A_CTRL, 8'h01);
    wr(A_LO, 8'h00); wr(A_HI, 8'hD0);
    wr(A_CTRL, 8'h55);
    exp_ptr(16'hD000, "R12 shadow active after setup");
    acc(1'b1);
    exp_ptr(16'h0000, "R12 main active after first read");
    acc(1'b1);
    exp_ptr(16'hD001, "R12 shadow advanced");
    acc(1'b1); acc(1'b1);
    exp_ptr(16'hD002, "R12 shadow after two rounds");
    exp_rd(A_CTRL, 8'h55, "R12 control after loop");
    wr(A_CTRL, 8'h54);
    exp_ptr(16'h0002, "R12 main after two rounds");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule